// File: doc/BRIEF.md
# Unaligned Word Load Merge Unit

This block forms the register write value for three kinds of load on a memory that only delivers naturally aligned words. An ordinary word load takes the fetched word as it is, but only when the byte address is aligned. A misaligned ordinary load raises an alignment fault and leaves the destination register alone. Two partial loads, an upper-part load and a lower-part load, each take one aligned word. They move a run of its bytes into one end of the destination register and keep the register's other bytes as they were.

Software reads a word at any byte address A with a pair of partial loads. One is a lower-part load at A and the other is an upper-part load at A+3, issued in either order, the second taking the first one's result as its old register value. Neither load reaches past its own aligned word. The bytes both loads write agree, so the pair leaves the unaligned word in the register. The caller supplies the aligned memory word, the byte offset within that word (the low address bits), the old register value and an operation code. The unit registers the merged value, a write enable and a fault flag.

Top module: `ulm_merge_unit`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released with no request, res_valid, res_we and res_fault are 0 and res_data is 0.
- R2: A request sampled on a rising clock edge with in_valid high shows its result on the outputs from that edge until the next one, with res_valid high. After an edge with in_valid low, res_valid, res_we and res_fault are 0 and res_data holds its previous value.
- R3: An ordinary load (in_op = 2'b00) at byte offset 0 gives res_data = in_word, res_we = 1 and res_fault = 0.
- R4: An ordinary load at a non-zero byte offset gives res_fault = 1 and res_we = 0, and res_data equals in_old.
- R5: An upper-part load (in_op = 2'b01) at byte offset k copies word bytes 0..k into register bytes 3-k..3, in the same order. Register bytes below 3-k keep in_old, and res_we = 1. Byte j of a word or register is bits 8j+7..8j, so byte 0 is the least-significant byte.
- R6: A lower-part load (in_op = 2'b10) at byte offset k copies word bytes k..3 into register bytes 0..3-k, in the same order. Register bytes above 3-k keep in_old, and res_we = 1.
- R7: A lower-part load at byte address A and an upper-part load at A+3, issued in either order with the second using the first one's result as in_old, leave memory bytes A..A+3 in register bytes 0..3. The memory word used by each load is the aligned word that contains its address.
- R8: Operation code 2'b11 writes nothing and faults nothing: res_we = 0, res_fault = 0, res_data = in_old.
- R9: Partial loads never raise res_fault, at any byte offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 2 | 00 word load, 01 upper-part load, 10 lower-part load, 11 no operation |
| in_offs | input | 2 | Low bits of the byte address, offset within the aligned word |
| in_word | input | 32 | Aligned memory word holding the addressed byte |
| in_old | input | 32 | Present value of the destination register |
| res_valid | output | 1 | Result registered from a request |
| res_data | output | 32 | Merged register value |
| res_we | output | 1 | Destination register is to be written |
| res_fault | output | 1 | Alignment fault on an ordinary load |

## Verification
Each result is due exactly one rising edge after its request is sampled, because the merge and the decode are combinational ahead of a single output register. The bench drives every request on a falling edge and reads the outputs on the next falling edge, which lies halfway between the capturing edge and the following one. It then drops in_valid at that same falling edge, so the idle-edge behaviour of R2 is checked one edge later in the same way. In the R7 pair tests, the second load's old value is the first load's registered result, and it is taken only after that result is due.

// File: rtl/ulm_pkg.sv
// Shared types for the unaligned load merge unit.
package ulm_pkg;
    // Operation codes carried on the in_op port.
    typedef enum logic [1:0] {
        OP_WORD  = 2'b00,
        OP_UPPER = 2'b01,
        OP_LOWER = 2'b10,
        OP_NONE  = 2'b11
    } ulm_op_e;
endpackage

// File: rtl/ulm_op_decode.sv
// Decodes the operation and byte offset into lane controls.
// Assumes NB is a power of two and at least 2; purely combinational.
module ulm_op_decode #(
    parameter int NB   = 4,
    localparam int OFFW = $clog2(NB)
) (
    input  logic            in_valid,
    input  logic [1:0]      in_op,
    input  logic [OFFW-1:0] in_offs,
    output logic            sel_word,
    output logic            sel_upper,
    output logic            sel_lower,
    output logic            fault,
    output logic            write
);
    import ulm_pkg::*;

    logic aligned;

    // Classify the request and flag misaligned ordinary loads.
    always_comb begin
        aligned   = (in_offs == '0);
        sel_word  = in_valid && (in_op == OP_WORD) && aligned;
        sel_upper = in_valid && (in_op == OP_UPPER);
        sel_lower = in_valid && (in_op == OP_LOWER);
        fault     = in_valid && (in_op == OP_WORD) && !aligned;
        write     = sel_word || sel_upper || sel_lower;
    end
endmodule

// File: rtl/ulm_byte_lane.sv
// Produces one destination register byte. The lane picks a byte of the
// aligned memory word or keeps the old register byte, per the decoded
// operation. Assumes NB is a power of two, so index wrap is modulo NB.
module ulm_byte_lane #(
    parameter int NB     = 4,
    parameter int BYTE_W = 8,
    parameter int LANE   = 0,
    localparam int OFFW  = $clog2(NB),
    localparam int SUMW  = OFFW + 1
) (
    input  logic                 sel_word,
    input  logic                 sel_upper,
    input  logic                 sel_lower,
    input  logic [OFFW-1:0]      offs,
    input  logic [NB*BYTE_W-1:0] mem_word,
    input  logic [BYTE_W-1:0]    old_byte,
    output logic [BYTE_W-1:0]    new_byte
);
    logic [BYTE_W-1:0] wbytes [NB];
    logic [SUMW-1:0]   pos_sum;
    logic [OFFW-1:0]   up_idx;
    logic [OFFW-1:0]   lo_idx;
    logic              up_take;
    logic              lo_take;

    // Split the memory word into its byte lanes.
    for (genvar b = 0; b < NB; b++) begin : g_split
        assign wbytes[b] = mem_word[b*BYTE_W +: BYTE_W];
    end

    // Choose the source byte for this lane, or keep the old byte.
    always_comb begin
        pos_sum  = {1'b0, offs} + SUMW'(LANE);
        up_take  = sel_upper && (pos_sum >= SUMW'(NB - 1));
        lo_take  = sel_lower && (pos_sum <= SUMW'(NB - 1));
        up_idx   = offs + OFFW'(LANE) + OFFW'(1);
        lo_idx   = offs + OFFW'(LANE);
        new_byte = old_byte;
        if (sel_word)     new_byte = wbytes[LANE];
        else if (up_take) new_byte = wbytes[up_idx];
        else if (lo_take) new_byte = wbytes[lo_idx];
    end
endmodule

// File: rtl/ulm_result_reg.sv
// Output register stage: captures merged data, write enable and fault
// when a request is present; holds data and clears flags otherwise.
module ulm_result_reg #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] nxt_data,
    input  logic          nxt_we,
    input  logic          nxt_fault,
    output logic          res_valid,
    output logic [DW-1:0] res_data,
    output logic          res_we,
    output logic          res_fault
);
    // Register the result with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            res_we    <= 1'b0;
            res_fault <= 1'b0;
        end else begin
            res_valid <= in_valid;
            res_we    <= in_valid && nxt_we;
            res_fault <= in_valid && nxt_fault;
            if (in_valid) res_data <= nxt_data;
        end
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && !res_we && !res_fault && $stable(res_data)));

    // R2
    req_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
endmodule

// File: rtl/ulm_merge_unit.sv
// Top of the unaligned word load merge unit. Combines op decode, one
// byte lane per register byte and a single output register stage.
// Assumes in_word is the aligned word holding the addressed byte and
// in_offs holds the low byte-address bits.
module ulm_merge_unit #(
    parameter int NB     = 4,
    parameter int BYTE_W = 8,
    localparam int OFFW  = $clog2(NB),
    localparam int DW    = NB * BYTE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      in_op,
    input  logic [OFFW-1:0] in_offs,
    input  logic [DW-1:0]   in_word,
    input  logic [DW-1:0]   in_old,
    output logic            res_valid,
    output logic [DW-1:0]   res_data,
    output logic            res_we,
    output logic            res_fault
);
    import ulm_pkg::*;

    logic          sel_word;
    logic          sel_upper;
    logic          sel_lower;
    logic          dec_fault;
    logic          dec_write;
    logic [DW-1:0] merged;

    ulm_op_decode #(.NB(NB)) u_dec (
        .in_valid (in_valid),
        .in_op    (in_op),
        .in_offs  (in_offs),
        .sel_word (sel_word),
        .sel_upper(sel_upper),
        .sel_lower(sel_lower),
        .fault    (dec_fault),
        .write    (dec_write)
    );

    for (genvar l = 0; l < NB; l++) begin : g_lane
        ulm_byte_lane #(.NB(NB), .BYTE_W(BYTE_W), .LANE(l)) u_lane (
            .sel_word (sel_word),
            .sel_upper(sel_upper),
            .sel_lower(sel_lower),
            .offs     (in_offs),
            .mem_word (in_word),
            .old_byte (in_old[l*BYTE_W +: BYTE_W]),
            .new_byte (merged[l*BYTE_W +: BYTE_W])
        );
    end

    ulm_result_reg #(.DW(DW)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .nxt_data (merged),
        .nxt_we   (dec_write),
        .nxt_fault(dec_fault),
        .res_valid(res_valid),
        .res_data (res_data),
        .res_we   (res_we),
        .res_fault(res_fault)
    );

    // R3
    word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_WORD && in_offs == '0)
        |=> (res_data == $past(in_word) && res_we && !res_fault));

    // R4
    misalign_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_WORD && in_offs != '0)
        |=> (res_fault && !res_we && res_data == $past(in_old)));

    // R5
    upper_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_UPPER && in_offs == OFFW'(NB - 1))
        |=> (res_data == $past(in_word)));

    // R5
    upper_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_UPPER && in_offs != OFFW'(NB - 1))
        |=> (res_data[BYTE_W-1:0] == $past(in_old[BYTE_W-1:0])));

    // R6
    lower_keeps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_LOWER && in_offs != '0)
        |=> (res_data[DW-1 -: BYTE_W] == $past(in_old[DW-1 -: BYTE_W])));

    // R8
    noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_NONE)
        |=> (!res_we && !res_fault && res_data == $past(in_old)));

    // R9
    partial_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == OP_UPPER || in_op == OP_LOWER))
        |=> (!res_fault && res_we));
endmodule

// File: tb/tb_ulm_merge_unit.sv
`timescale 1ns/1ps
module tb_ulm_merge_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  in_op;
    logic [1:0]  in_offs;
    logic [31:0] in_word;
    logic [31:0] in_old;
    logic        res_valid;
    logic [31:0] res_data;
    logic        res_we;
    logic        res_fault;

    int checks = 0;
    int failures = 0;
    logic [7:0] mem [12];

    always #10 clk = ~clk;

    ulm_merge_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_offs(in_offs), .in_word(in_word), .in_old(in_old),
        .res_valid(res_valid), .res_data(res_data), .res_we(res_we),
        .res_fault(res_fault)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected merged value computed from the requirement text.
    function automatic logic [31:0] exp_data(input logic [1:0] op, input int k,
                                             input logic [31:0] w, input logic [31:0] o);
        logic [63:0] sh;
        logic [63:0] mk;
        case (op)
            2'b00: exp_data = (k == 0) ? w : o;
            2'b01: begin
                sh = {32'b0, w} << (8 * (3 - k));
                mk = (64'h1 << (8 * (3 - k))) - 64'h1;
                exp_data = sh[31:0] | (o & mk[31:0]);
            end
            2'b10: begin
                sh = {32'b0, w} >> (8 * k);
                mk = ~((64'h1 << (32 - 8 * k)) - 64'h1);
                exp_data = sh[31:0] | (o & mk[31:0]);
            end
            default: exp_data = o;
        endcase
    endfunction

    // Drive a request on a falling edge; result is read one edge later.
    task automatic run_op(input logic [1:0] op, input logic [1:0] k,
                          input logic [31:0] w, input logic [31:0] o);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_offs = k; in_word = w; in_old = o;
        @(negedge clk);
    endtask

    function automatic logic [31:0] word_at(input int a);
        int b;
        b = a & ~3;
        return {mem[b+3], mem[b+2], mem[b+1], mem[b]};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] w, o, r1;
        rst_n = 1'b0; in_valid = 1'b0; in_op = 2'b00; in_offs = 2'b00;
        in_word = '0; in_old = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", {31'b0, res_valid}, 32'h0);
        chk("R1 reset data", res_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset flags", {29'b0, res_valid, res_we, res_fault}, 32'h0);
        chk("R1 idle after reset data", res_data, 32'h0);

        // Sweep every op and offset over several data patterns.
        for (int p = 0; p < 6; p++) begin
            w = 32'h9E37_79B9 * (p + 1);
            o = ~w ^ (32'h5A5A_0F0F * (p + 3));
            for (int op = 0; op < 4; op++) begin
                for (int k = 0; k < 4; k++) begin
                    logic exp_we, exp_f;
                    run_op(op[1:0], k[1:0], w, o);
                    exp_we = (op == 1 || op == 2 || (op == 0 && k == 0));
                    exp_f  = (op == 0 && k != 0);
                    chk("R2 result valid", {31'b0, res_valid}, 32'h1);
                    case (op)
                        0: if (k == 0) begin
                               chk("R3 word data", res_data, exp_data(2'b00, k, w, o));
                               chk("R3 word we/fault", {30'b0, res_we, res_fault}, {30'b0, exp_we, exp_f});
                           end else begin
                               chk("R4 misaligned data", res_data, exp_data(2'b00, k, w, o));
                               chk("R4 misaligned we/fault", {30'b0, res_we, res_fault}, {30'b0, exp_we, exp_f});
                           end
                        1: begin
                               chk("R5 upper data", res_data, exp_data(2'b01, k, w, o));
                               chk("R9 upper we/fault", {30'b0, res_we, res_fault}, {30'b0, exp_we, exp_f});
                           end
                        2: begin
                               chk("R6 lower data", res_data, exp_data(2'b10, k, w, o));
                               chk("R9 lower we/fault", {30'b0, res_we, res_fault}, {30'b0, exp_we, exp_f});
                           end
                        default: begin
                               chk("R8 noop data", res_data, o);
                               chk("R8 noop we/fault", {30'b0, res_we, res_fault}, 32'h0);
                           end
                    endcase
                    in_valid = 1'b0;
                end
            end
        end

        // Idle edge: flags clear and data held.
        r1 = res_data;
        @(negedge clk);
        chk("R2 idle flags", {29'b0, res_valid, res_we, res_fault}, 32'h0);
        chk("R2 idle data held", res_data, r1);

        // Pair of partial loads assembles any unaligned word.
        for (int i = 0; i < 12; i++) mem[i] = 8'(8'h10 + i * 7 + (i << 4));
        for (int a = 0; a < 9; a++) begin
            logic [31:0] exp_w;
            exp_w = {mem[a+3], mem[a+2], mem[a+1], mem[a]};
            run_op(2'b10, 2'(a), word_at(a), 32'hDEAD_BEEF);
            r1 = res_data;
            in_valid = 1'b0;
            run_op(2'b01, 2'(a + 3), word_at(a + 3), r1);
            chk("R7 lower then upper", res_data, exp_w);
            in_valid = 1'b0;
            run_op(2'b01, 2'(a + 3), word_at(a + 3), 32'h0BAD_F00D);
            r1 = res_data;
            in_valid = 1'b0;
            run_op(2'b10, 2'(a), word_at(a), r1);
            chk("R7 upper then lower", res_data, exp_w);
            in_valid = 1'b0;
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule